// File: doc/BRIEF.md
# OUT Endpoint Receive Buffer with One or Two Banks

This block stores the packets that a host sends to one OUT endpoint until the CPU has taken them. The link side marks a packet with a start strobe, then delivers bytes with a valid qualifier, and closes it with an end strobe that carries a good/bad verdict. The block replies with a one-cycle ACK or NAK pulse. Each packet lands in a bank. There are one or two banks, chosen by a parameter, and each bank holds 8 to 64 bytes.

The CPU sees a small set of register-style controls and status bits. Hardware sets the received flag and the bank-held bit together when the bank the CPU is looking at fills. The CPU acknowledges by writing zero to the flag. It then pops the bytes through a data port while a remaining-byte count and a read-allowed bit track progress. It hands the bank back by writing zero to the bank-held bit. With two banks, the link may fill the second bank while the CPU still works on the first. Releasing a bank moves the CPU to the other bank, and both flags are reloaded from that bank's state. Banks are written and read in strict alternation.

Top module: `out_ep_buffer`

## Requirements
- R1: A packet that ends with `pkt_good`=1 and no overflow is committed only if its write bank was empty at `pkt_start`. In that case `hs_ack` pulses for exactly one cycle, one clock after the `pkt_end` cycle. If that bank is the CPU's current bank, `rx_flag` and `bank_held` both read 1 from that same cycle.
- R2: `ep_irq` is 1 exactly when `rx_flag` is 1 and the enable bit is 1. The enable bit is loaded from `cpu_ie_wdata` in a cycle with `cpu_ie_wr`=1.
- R3: A `cpu_flag_wr` cycle with `cpu_flag_wdata`=0 clears `rx_flag` on the next clock. A write with `cpu_flag_wdata`=1 leaves `rx_flag` unchanged.
- R4: A `cpu_rel_wr` cycle with `cpu_rel_wdata`=0, while `bank_held`=1 and `rx_flag`=0, empties the current bank. With two banks, it also switches the current bank to the other bank.
- R5: After a release, `rx_flag` and `bank_held` both take the full/empty state of the new current bank. Both read 1 if that bank already holds a packet, and both read 0 otherwise.
- R6: `rd_allowed` is 1 only while the current bank holds a packet with unread bytes. It falls to 0 once the last byte has been popped, and it stays 0 for a zero-length packet.
- R7: With one bank, a good packet that starts while the bank holds a packet gets a one-cycle `hs_nak` and leaves the stored data intact. The first good packet after the release gets `hs_ack`.
- R8: With two banks, a packet that arrives while the CPU holds bank 0 is stored in bank 1 and acknowledged. A third packet, arriving while both banks are full, gets a NAK. After bank 0 is released, the CPU reads bank 1's bytes.
- R9: `rd_count` gives the number of bytes not yet popped from the current bank, and is 0 for an empty bank. `rd_data` shows the next byte in arrival order. Each `cpu_pop` cycle while `rd_allowed`=1 advances to the next byte and lowers `rd_count` by one.
- R10: A release write made while `rx_flag`=1 is ignored, and the bank stays held.
- R11: A packet that ends with `pkt_good`=0 produces neither ACK nor NAK, and leaves its write bank empty for the next packet.
- R12: A packet carrying more bytes than `BANK_BYTES` is discarded with no handshake, and its bank stays empty. A packet of exactly `BANK_BYTES` bytes is accepted.
- R13: After reset, all banks are empty and the current bank is bank 0. `rx_flag`, `bank_held`, `rd_allowed`, `ep_irq`, `hs_ack`, `hs_nak` and `rd_count` all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_start | input | 1 | One-cycle strobe that opens a packet |
| pkt_valid | input | 1 | `pkt_data` carries a packet byte this cycle |
| pkt_data | input | DATA_W | Packet byte |
| pkt_end | input | 1 | One-cycle strobe that closes a packet, in a cycle of its own after the last byte |
| pkt_good | input | 1 | Verdict sampled with `pkt_end`: 1 means good |
| hs_ack | output | 1 | One-cycle ACK pulse |
| hs_nak | output | 1 | One-cycle NAK pulse |
| cpu_flag_wr | input | 1 | Write strobe for the received flag |
| cpu_flag_wdata | input | 1 | Value written to the received flag (0 clears) |
| cpu_rel_wr | input | 1 | Write strobe for the bank-held bit |
| cpu_rel_wdata | input | 1 | Value written to the bank-held bit (0 releases) |
| cpu_ie_wr | input | 1 | Write strobe for the interrupt enable |
| cpu_ie_wdata | input | 1 | Interrupt enable value |
| cpu_pop | input | 1 | Read strobe of the data port: moves on by one byte |
| rx_flag | output | 1 | Received-packet flag |
| bank_held | output | 1 | Current bank is owned by firmware |
| rd_allowed | output | 1 | Current bank has unread bytes |
| rd_count | output | 7 | Unread bytes in the current bank |
| rd_data | output | DATA_W | Next byte of the current bank |
| ep_irq | output | 1 | Endpoint interrupt |

## Verification
The bench drives the ownership handshake in the wrong order. A release issued while the flag is still set must leave the bank held; a design that honoured it would free data the CPU has not yet acknowledged. With one bank, it sends a packet into a held bank and expects a NAK with the old bytes still intact. With two banks, it fills both banks and expects the third packet to be refused. After the release, both flags must come straight back from the second bank; a design that simply cleared them would hide a waiting packet. Overflow by a single byte, an exact-fit packet, a zero-length packet and a bad-verdict packet each check that no handshake is sent where none is due, and that the write bank is not left wrongly marked full.

// File: rtl/oeb_pkg.sv
package oeb_pkg;

    localparam int unsigned OEB_MAX_BYTES = 64;
    localparam int unsigned OEB_CNT_W     = $clog2(OEB_MAX_BYTES + 1);

    typedef logic [OEB_CNT_W-1:0] oeb_cnt_t;

    // Per-bank bookkeeping: occupancy, stored length, CPU read position.
    typedef struct packed {
        logic     full;
        oeb_cnt_t cnt;
        oeb_cnt_t rptr;
    } oeb_bank_t;

    // Link-side receive state.
    typedef struct packed {
        logic     busy;
        logic     accept;
        logic     ovf;
        oeb_cnt_t wptr;
        logic     wbank;
        logic     ack;
        logic     nak;
    } oeb_rx_t;

endpackage

// File: rtl/oeb_bank_mem.sv
module oeb_bank_mem #(
    parameter int unsigned NUM_BANKS  = 2,
    parameter int unsigned BANK_BYTES = 64,
    parameter int unsigned DATA_W     = 8,
    localparam int unsigned IDX_W     = $clog2(BANK_BYTES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wbank,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rbank,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] bank_rd [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [DATA_W-1:0] store [BANK_BYTES];

        always_ff @(posedge clk) begin
            if (we && (wbank == 1'(g))) begin
                store[widx] <= wdata;
            end
        end

        assign bank_rd[g] = store[ridx];
    end

    if (NUM_BANKS == 1) begin : g_rd_one
        logic unused_rbank;
        assign unused_rbank = rbank;
        assign rdata        = bank_rd[0];
    end else begin : g_rd_two
        assign rdata = bank_rd[rbank];
    end

endmodule

// File: rtl/oeb_rx_fill.sv
module oeb_rx_fill
    import oeb_pkg::*;
#(
    parameter int unsigned NUM_BANKS  = 2,
    parameter int unsigned BANK_BYTES = 64,
    localparam int unsigned IDX_W     = $clog2(BANK_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pkt_start,
    input  logic                 pkt_valid,
    input  logic                 pkt_end,
    input  logic                 pkt_good,
    input  logic [NUM_BANKS-1:0] bank_full,
    output logic                 mem_we,
    output logic                 mem_bank,
    output logic [IDX_W-1:0]     mem_idx,
    output logic                 commit,
    output logic                 commit_bank,
    output oeb_cnt_t             commit_cnt,
    output logic                 hs_ack,
    output logic                 hs_nak
);

    localparam oeb_cnt_t LIMIT = oeb_cnt_t'(BANK_BYTES);
    localparam oeb_cnt_t ONE   = oeb_cnt_t'(1);

    oeb_rx_t rx_d, rx_q;
    logic    target_full;

    if (NUM_BANKS == 1) begin : g_full_one
        assign target_full = bank_full[0];
    end else begin : g_full_two
        assign target_full = bank_full[rx_q.wbank];
    end

    always_comb begin
        rx_d     = rx_q;
        rx_d.ack = 1'b0;
        rx_d.nak = 1'b0;
        mem_we   = 1'b0;
        commit   = 1'b0;

        if (pkt_start) begin
            // A packet is taken only if its bank is empty when it opens.
            rx_d.busy   = 1'b1;
            rx_d.accept = !target_full;
            rx_d.ovf    = 1'b0;
            rx_d.wptr   = '0;
        end else if (rx_q.busy && pkt_end) begin
            rx_d.busy = 1'b0;
            if (rx_q.accept && pkt_good && !rx_q.ovf) begin
                commit     = 1'b1;
                rx_d.ack   = 1'b1;
                rx_d.wbank = (NUM_BANKS == 2) ? ~rx_q.wbank : 1'b0;
            end else if (!rx_q.accept && pkt_good) begin
                rx_d.nak = 1'b1;
            end
        end else if (rx_q.busy && pkt_valid && rx_q.accept && !rx_q.ovf) begin
            if (rx_q.wptr == LIMIT) begin
                rx_d.ovf = 1'b1;
            end else begin
                mem_we    = 1'b1;
                rx_d.wptr = rx_q.wptr + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign mem_bank    = rx_q.wbank;
    assign mem_idx     = rx_q.wptr[IDX_W-1:0];
    assign commit_bank = rx_q.wbank;
    assign commit_cnt  = rx_q.wptr;
    assign hs_ack      = rx_q.ack;
    assign hs_nak      = rx_q.nak;

endmodule

// File: rtl/oeb_cpu_ctrl.sv
module oeb_cpu_ctrl
    import oeb_pkg::*;
#(
    parameter int unsigned NUM_BANKS  = 2,
    parameter int unsigned BANK_BYTES = 64,
    localparam int unsigned IDX_W     = $clog2(BANK_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit,
    input  logic                 commit_bank,
    input  oeb_cnt_t             commit_cnt,
    input  logic                 cpu_flag_wr,
    input  logic                 cpu_flag_wdata,
    input  logic                 cpu_rel_wr,
    input  logic                 cpu_rel_wdata,
    input  logic                 cpu_ie_wr,
    input  logic                 cpu_ie_wdata,
    input  logic                 cpu_pop,
    output logic [NUM_BANKS-1:0] bank_full,
    output logic                 cur_bank,
    output logic [IDX_W-1:0]     rd_idx,
    output logic                 rx_flag,
    output logic                 bank_held,
    output logic                 rd_allowed,
    output oeb_cnt_t             rd_count,
    output logic                 ep_irq
);

    localparam oeb_cnt_t ONE = oeb_cnt_t'(1);

    typedef struct packed {
        oeb_bank_t [NUM_BANKS-1:0] banks;
        logic                      cur;
        logic                      flag;
        logic                      own;
        logic                      ie;
    } ctrl_t;

    ctrl_t     st_d, st_q;
    oeb_bank_t cur_b;
    logic      clr_flag;
    logic      do_rel;
    logic      rd_ok;

    always_comb begin
        st_d     = st_q;
        cur_b    = st_q.banks[st_q.cur];
        rd_ok    = cur_b.full && (cur_b.rptr < cur_b.cnt);
        clr_flag = cpu_flag_wr && !cpu_flag_wdata && st_q.flag;
        // Ownership returns only after the flag has been acknowledged.
        do_rel   = cpu_rel_wr && !cpu_rel_wdata && st_q.own && !st_q.flag;

        if (cpu_ie_wr) begin
            st_d.ie = cpu_ie_wdata;
        end
        if (clr_flag) begin
            st_d.flag = 1'b0;
        end
        if (cpu_pop && rd_ok && !do_rel) begin
            st_d.banks[st_q.cur].rptr = cur_b.rptr + ONE;
        end
        if (commit) begin
            st_d.banks[commit_bank].full = 1'b1;
            st_d.banks[commit_bank].cnt  = commit_cnt;
            st_d.banks[commit_bank].rptr = '0;
        end

        if (do_rel) begin
            st_d.banks[st_q.cur] = '0;
            st_d.cur  = (NUM_BANKS == 2) ? ~st_q.cur : 1'b0;
            st_d.flag = st_d.banks[st_d.cur].full;
            st_d.own  = st_d.banks[st_d.cur].full;
        end else if (commit && (commit_bank == st_q.cur)) begin
            st_d.flag = 1'b1;
            st_d.own  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_full
        assign bank_full[g] = st_q.banks[g].full;
    end

    assign cur_bank   = st_q.cur;
    assign rd_idx     = cur_b.rptr[IDX_W-1:0];
    assign rx_flag    = st_q.flag;
    assign bank_held  = st_q.own;
    assign rd_allowed = rd_ok;
    assign rd_count   = cur_b.full ? (cur_b.cnt - cur_b.rptr) : '0;
    assign ep_irq     = st_q.flag && st_q.ie;

endmodule

// File: rtl/out_ep_buffer.sv
module out_ep_buffer
    import oeb_pkg::*;
#(
    parameter int unsigned NUM_BANKS  = 2,
    parameter int unsigned BANK_BYTES = 64,
    parameter int unsigned DATA_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pkt_start,
    input  logic                 pkt_valid,
    input  logic [DATA_W-1:0]    pkt_data,
    input  logic                 pkt_end,
    input  logic                 pkt_good,
    output logic                 hs_ack,
    output logic                 hs_nak,
    input  logic                 cpu_flag_wr,
    input  logic                 cpu_flag_wdata,
    input  logic                 cpu_rel_wr,
    input  logic                 cpu_rel_wdata,
    input  logic                 cpu_ie_wr,
    input  logic                 cpu_ie_wdata,
    input  logic                 cpu_pop,
    output logic                 rx_flag,
    output logic                 bank_held,
    output logic                 rd_allowed,
    output logic [OEB_CNT_W-1:0] rd_count,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 ep_irq
);

    localparam int unsigned IDX_W = $clog2(BANK_BYTES);

    logic [NUM_BANKS-1:0] bank_full;
    logic                 mem_we;
    logic                 mem_bank;
    logic [IDX_W-1:0]     mem_idx;
    logic                 commit;
    logic                 commit_bank;
    oeb_cnt_t             commit_cnt;
    logic                 cur_bank;
    logic [IDX_W-1:0]     rd_idx;

    oeb_rx_fill #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_BYTES(BANK_BYTES)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_start  (pkt_start),
        .pkt_valid  (pkt_valid),
        .pkt_end    (pkt_end),
        .pkt_good   (pkt_good),
        .bank_full  (bank_full),
        .mem_we     (mem_we),
        .mem_bank   (mem_bank),
        .mem_idx    (mem_idx),
        .commit     (commit),
        .commit_bank(commit_bank),
        .commit_cnt (commit_cnt),
        .hs_ack     (hs_ack),
        .hs_nak     (hs_nak)
    );

    oeb_cpu_ctrl #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_BYTES(BANK_BYTES)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit        (commit),
        .commit_bank   (commit_bank),
        .commit_cnt    (commit_cnt),
        .cpu_flag_wr   (cpu_flag_wr),
        .cpu_flag_wdata(cpu_flag_wdata),
        .cpu_rel_wr    (cpu_rel_wr),
        .cpu_rel_wdata (cpu_rel_wdata),
        .cpu_ie_wr     (cpu_ie_wr),
        .cpu_ie_wdata  (cpu_ie_wdata),
        .cpu_pop       (cpu_pop),
        .bank_full     (bank_full),
        .cur_bank      (cur_bank),
        .rd_idx        (rd_idx),
        .rx_flag       (rx_flag),
        .bank_held     (bank_held),
        .rd_allowed    (rd_allowed),
        .rd_count      (rd_count),
        .ep_irq        (ep_irq)
    );

    oeb_bank_mem #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_BYTES(BANK_BYTES),
        .DATA_W    (DATA_W)
    ) u_mem (
        .clk  (clk),
        .we   (mem_we),
        .wbank(mem_bank),
        .widx (mem_idx),
        .wdata(pkt_data),
        .rbank(cur_bank),
        .ridx (rd_idx),
        .rdata(rd_data)
    );

endmodule

// File: rtl/oeb_checker.sv
module oeb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_ack,
    input logic       hs_nak,
    input logic       cpu_flag_wr,
    input logic       cpu_flag_wdata,
    input logic       cpu_rel_wr,
    input logic       cpu_rel_wdata,
    input logic       cpu_pop,
    input logic       rx_flag,
    input logic       bank_held,
    input logic       rd_allowed,
    input logic [6:0] rd_count,
    input logic       ep_irq
);

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ep_irq |-> rx_flag); // R2
    AST_FLAG_WITH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> bank_held); // R1
    AST_HS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_ack && hs_nak)); // R1
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ack |=> !hs_ack); // R1
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_flag_wr && !cpu_flag_wdata && rx_flag) |=> !rx_flag); // R3
    AST_FLAG_W1_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_flag_wr && cpu_flag_wdata && rx_flag) |=> rx_flag); // R3
    AST_RELEASE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rel_wr && !cpu_rel_wdata && rx_flag) |=> bank_held); // R10
    AST_READ_NEEDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_allowed |-> bank_held); // R6
    AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_pop && rd_allowed && !cpu_rel_wr) |=> (rd_count == $past(rd_count) - 7'd1)); // R9

endmodule

bind out_ep_buffer oeb_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hs_ack        (hs_ack),
    .hs_nak        (hs_nak),
    .cpu_flag_wr   (cpu_flag_wr),
    .cpu_flag_wdata(cpu_flag_wdata),
    .cpu_rel_wr    (cpu_rel_wr),
    .cpu_rel_wdata (cpu_rel_wdata),
    .cpu_pop       (cpu_pop),
    .rx_flag       (rx_flag),
    .bank_held     (bank_held),
    .rd_allowed    (rd_allowed),
    .rd_count      (rd_count),
    .ep_irq        (ep_irq)
);

// File: tb/tb_out_ep_buffer.sv
`timescale 1ns/1ps
module tb_out_ep_buffer;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_start = 0, pkt_valid = 0, pkt_end = 0, pkt_good = 0;
    logic [7:0] pkt_data = '0;
    logic cpu_flag_wr = 0, cpu_flag_wdata = 0, cpu_rel_wr = 0, cpu_rel_wdata = 0;
    logic cpu_ie_wr = 0, cpu_ie_wdata = 0, cpu_pop = 0;

    logic ack_a, nak_a, flag_a, held_a, rdal_a, irq_a;
    logic [6:0] cnt_a;
    logic [7:0] data_a;
    logic ack_b, nak_b, flag_b, held_b, rdal_b, irq_b;
    logic [6:0] cnt_b;
    logic [7:0] data_b;

    int  n_chk = 0;
    int  n_err = 0;
    bit  sel = 1'b0;   // 0: two-bank dut, 1: one-bank dut1

    always #4 clk = ~clk;

    out_ep_buffer #(.NUM_BANKS(2), .BANK_BYTES(64)) dut (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_valid(pkt_valid),
        .pkt_data(pkt_data), .pkt_end(pkt_end), .pkt_good(pkt_good),
        .hs_ack(ack_a), .hs_nak(nak_a), .cpu_flag_wr(cpu_flag_wr),
        .cpu_flag_wdata(cpu_flag_wdata), .cpu_rel_wr(cpu_rel_wr),
        .cpu_rel_wdata(cpu_rel_wdata), .cpu_ie_wr(cpu_ie_wr),
        .cpu_ie_wdata(cpu_ie_wdata), .cpu_pop(cpu_pop), .rx_flag(flag_a),
        .bank_held(held_a), .rd_allowed(rdal_a), .rd_count(cnt_a),
        .rd_data(data_a), .ep_irq(irq_a));

    out_ep_buffer #(.NUM_BANKS(1), .BANK_BYTES(8)) dut1 (
        .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_valid(pkt_valid),
        .pkt_data(pkt_data), .pkt_end(pkt_end), .pkt_good(pkt_good),
        .hs_ack(ack_b), .hs_nak(nak_b), .cpu_flag_wr(cpu_flag_wr),
        .cpu_flag_wdata(cpu_flag_wdata), .cpu_rel_wr(cpu_rel_wr),
        .cpu_rel_wdata(cpu_rel_wdata), .cpu_ie_wr(cpu_ie_wr),
        .cpu_ie_wdata(cpu_ie_wdata), .cpu_pop(cpu_pop), .rx_flag(flag_b),
        .bank_held(held_b), .rd_allowed(rdal_b), .rd_count(cnt_b),
        .rd_data(data_b), .ep_irq(irq_b));

    function automatic int o_ack();  return sel ? int'(ack_b)  : int'(ack_a);  endfunction
    function automatic int o_nak();  return sel ? int'(nak_b)  : int'(nak_a);  endfunction
    function automatic int o_flag(); return sel ? int'(flag_b) : int'(flag_a); endfunction
    function automatic int o_held(); return sel ? int'(held_b) : int'(held_a); endfunction
    function automatic int o_rdal(); return sel ? int'(rdal_b) : int'(rdal_a); endfunction
    function automatic int o_irq();  return sel ? int'(irq_b)  : int'(irq_a);  endfunction
    function automatic int o_cnt();  return sel ? int'(cnt_b)  : int'(cnt_a);  endfunction
    function automatic int o_data(); return sel ? int'(data_b) : int'(data_a); endfunction

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic send_pkt(input int len, input int seed, input bit good,
                            output int ack, output int nak);
        pkt_start = 1'b1;
        step();
        pkt_start = 1'b0;
        for (int i = 0; i < len; i++) begin
            pkt_valid = 1'b1;
            pkt_data  = 8'(seed + i);
            step();
        end
        pkt_valid = 1'b0;
        pkt_end   = 1'b1;
        pkt_good  = good;
        step();
        pkt_end   = 1'b0;
        pkt_good  = 1'b0;
        ack = o_ack();
        nak = o_nak();
    endtask

    task automatic clr_flag();
        cpu_flag_wr = 1'b1; cpu_flag_wdata = 1'b0;
        step();
        cpu_flag_wr = 1'b0;
    endtask

    task automatic release_bank();
        cpu_rel_wr = 1'b1; cpu_rel_wdata = 1'b0;
        step();
        cpu_rel_wr = 1'b0;
    endtask

    task automatic read_bank(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            chk("R9 data", o_data(), (seed + i) & 255);
            chk("R9 count", o_cnt(), len - i);
            chk("R6 allowed mid", o_rdal(), 1);
            cpu_pop = 1'b1;
            step();
            cpu_pop = 1'b0;
        end
        chk("R6 allowed after last", o_rdal(), 0);
        chk("R9 count empty", o_cnt(), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic check_reset_state();
        chk("R13 flag", o_flag(), 0);
        chk("R13 held", o_held(), 0);
        chk("R13 allowed", o_rdal(), 0);
        chk("R13 count", o_cnt(), 0);
        chk("R13 irq", o_irq(), 0);
        chk("R13 ack", o_ack(), 0);
        chk("R13 nak", o_nak(), 0);
    endtask

    // {length, data seed}
    localparam logic [15:0] VEC [6] = '{16'h0311, 16'h0150, 16'h4000,
                                        16'h11A0, 16'h0077, 16'h08F8};

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog act=0 exp=1");
        summary();
        $finish;
    end

    initial begin
        int ack, nak;
        step();
        do_reset();

        // ---------- one-bank instance ----------
        sel = 1'b1;
        check_reset_state();
        cpu_ie_wr = 1'b1; cpu_ie_wdata = 1'b1;
        step();
        cpu_ie_wr = 1'b0;
        chk("R2 irq idle", o_irq(), 0);

        send_pkt(4, 8'h30, 1'b1, ack, nak);
        chk("R1 ack", ack, 1);
        chk("R1 no nak", nak, 0);
        chk("R1 flag", o_flag(), 1);
        chk("R1 held", o_held(), 1);
        chk("R2 irq set", o_irq(), 1);
        step();
        chk("R1 ack one cycle", o_ack(), 0);

        send_pkt(3, 8'h90, 1'b1, ack, nak);
        chk("R7 nak when held", nak, 1);
        chk("R7 no ack when held", ack, 0);

        release_bank();
        chk("R10 release ignored", o_held(), 1);

        cpu_flag_wr = 1'b1; cpu_flag_wdata = 1'b1;
        step();
        cpu_flag_wr = 1'b0;
        chk("R3 write one keeps flag", o_flag(), 1);

        clr_flag();
        chk("R3 flag cleared", o_flag(), 0);
        chk("R2 irq cleared", o_irq(), 0);
        read_bank(4, 8'h30);          // R7 old data intact
        chk("R6 still held", o_held(), 1);
        release_bank();
        chk("R4 released", o_held(), 0);
        chk("R5 flag reload empty", o_flag(), 0);

        send_pkt(9, 8'h01, 1'b1, ack, nak);
        chk("R12 overflow no ack", ack, 0);
        chk("R12 overflow no nak", nak, 0);
        chk("R12 bank empty", o_held(), 0);
        send_pkt(8, 8'h40, 1'b1, ack, nak);
        chk("R12 exact fit ack", ack, 1);
        chk("R7 ack after release", ack, 1);
        clr_flag();
        read_bank(8, 8'h40);
        release_bank();

        send_pkt(3, 8'h55, 1'b0, ack, nak);
        chk("R11 bad no ack", ack, 0);
        chk("R11 bad no nak", nak, 0);
        chk("R11 flag", o_flag(), 0);
        send_pkt(2, 8'h66, 1'b1, ack, nak);
        chk("R11 bank free after bad", ack, 1);

        // ---------- two-bank instance ----------
        do_reset();
        sel = 1'b0;
        check_reset_state();

        for (int v = 0; v < 6; v++) begin
            int len  = int'(VEC[v][15:8]);
            int seed = int'(VEC[v][7:0]);
            send_pkt(len, seed, 1'b1, ack, nak);
            chk("R1 table ack", ack, 1);
            chk("R1 table flag", o_flag(), 1);
            chk("R2 irq off when disabled", o_irq(), 0);
            clr_flag();
            read_bank(len, seed);
            release_bank();
            chk("R4 table released", o_held(), 0);
        end

        send_pkt(3, 8'h10, 1'b1, ack, nak);
        chk("R8 first ack", ack, 1);
        send_pkt(5, 8'h20, 1'b1, ack, nak);
        chk("R8 second ack into other bank", ack, 1);
        send_pkt(2, 8'hE0, 1'b1, ack, nak);
        chk("R8 nak both full", nak, 1);
        chk("R8 no ack both full", ack, 0);
        clr_flag();
        read_bank(3, 8'h10);
        release_bank();
        chk("R5 flag reloaded", o_flag(), 1);
        chk("R5 held reloaded", o_held(), 1);
        clr_flag();
        read_bank(5, 8'h20);          // R8 bank 1 contents
        release_bank();
        chk("R5 flag after second", o_flag(), 0);
        chk("R4 held after second", o_held(), 0);

        summary();
        $finish;
    end

endmodule